// File: doc/BRIEF.md
# Mains-Referenced Tenth-Second Timebase

This block generates a one-cycle tick every tenth of a second for a real-time clock. Its preferred reference is the power line: a 50 Hz or 60 Hz sine wave that has already been squared into a digital pulse. Whenever that reference cannot be trusted, it falls back to the 32.768 kHz crystal clock. The crystal clock also runs all of the block's logic. The mains pulse is synchronized into that domain. Each mains period is measured in crystal cycles and compared against a tolerance window. A run of good periods marks the line as trustworthy.

When the line is qualified and main power is present, ticks are counted from mains cycles. Otherwise they are counted from crystal cycles, in a fixed ten-tick pattern that totals exactly one second. When the source changes, the partial tick already accumulated is translated into the new unit and kept. As a result, the seconds count downstream neither skips nor repeats. A separate square-wave output gives one of seven crystal-derived frequencies, or is held low.

Top module: `mains_timebase`

## Requirements
- R1: While reset is asserted, `tick`, `ac_ready`, `src_ac` and `fout` are all 0, whatever `fout_sel` is.
- R2: In crystal mode, ticks of positions 0 to 7 of each ten-tick group last 3277 crystal cycles, and positions 8 and 9 last 3276 cycles. Ten ticks therefore total 32768 cycles. The position advances on every tick in either mode.
- R3: In mains mode, a tick is issued on every 6th mains rising edge when `line_50hz` = 0, and on every 5th when `line_50hz` = 1. Each rising edge is counted once.
- R4: `ac_ready` rises only after 8 consecutive mains periods fall inside the window. The window is the nominal period ±1/20, measured in crystal cycles: 519 to 573 at 60 Hz, and 623 to 687 at 50 Hz. The first edge after a gap only starts the measurement.
- R5: `ac_ready` falls after a single period outside the window. It also falls when no edge arrives within the window's upper bound.
- R6: `src_ac` is 1 (mains source) exactly when `ac_ready` = 1 and `pwr_fail` = 0, one cycle later. Otherwise `src_ac` is 0 (crystal source).
- R7: The tick interval that spans a source change stays within one mains period (plus synchronizer slack) of a nominal tenth-second. No tick is lost or doubled.
- R8: When `fout_sel` = 0, `fout` is held low. When `fout_sel` = s (1 to 7), `fout` is a square wave with a period of 2^(2s-1) crystal cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | 32.768 kHz crystal clock, drives all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ac_pulse | input | 1 | Squared mains waveform, asynchronous |
| line_50hz | input | 1 | 1 = 50 Hz line, 0 = 60 Hz line |
| pwr_fail | input | 1 | Main power has failed; force crystal source |
| fout_sel | input | 3 | Frequency output select, 0 = off |
| tick | output | 1 | One-cycle pulse every tenth of a second |
| ac_ready | output | 1 | Mains input qualified as timebase |
| src_ac | output | 1 | Active source: 1 mains, 0 crystal |
| fout | output | 1 | Selected square-wave output |

## Verification
The assertions assume that mains rising edges are hundreds of crystal cycles apart. They also assume each pulse stays high or low for more than the synchronizer depth, so no two detected edges are adjacent. The stimulus drives every input on the falling clock edge. It generates mains waveforms with whole-cycle periods of 546 or 655 cycles, with a single deliberately stretched period of 600 cycles, and with a full stop. `line_50hz` changes only while the mains input is idle. `fout_sel` is held steady while the frequency output is measured.

// File: rtl/mtb_pkg.sv
`timescale 1ns/1ps
package mtb_pkg;

  typedef enum logic {
    SRC_XTAL = 1'b0,
    SRC_AC   = 1'b1
  } src_e;

  // Nominal mains period in crystal cycles, rounded to nearest.
  function automatic int nom_period(input int xtal_hz, input int line_hz);
    return (xtal_hz + line_hz / 2) / line_hz;
  endfunction

endpackage

// File: rtl/mtb_edge_sync.sv
`timescale 1ns/1ps
module mtb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_in};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign rise = chain_q[STAGES-1] & ~prev_q;

  // R3
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise)
    else $error("edge detector fired on consecutive cycles");

endmodule

// File: rtl/mtb_ac_qual.sv
`timescale 1ns/1ps
module mtb_ac_qual import mtb_pkg::*; #(
  parameter int XTAL_HZ    = 32768,
  parameter int LINE_A_HZ  = 60,
  parameter int LINE_B_HZ  = 50,
  parameter int TOL_DIV    = 20,
  parameter int QUAL_CNT   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ac_edge,
  input  logic line_50hz,
  output logic ac_ready
);

  localparam int PA   = nom_period(XTAL_HZ, LINE_A_HZ);
  localparam int PB   = nom_period(XTAL_HZ, LINE_B_HZ);
  localparam int LO_A = PA - PA / TOL_DIV;
  localparam int HI_A = PA + PA / TOL_DIV;
  localparam int LO_B = PB - PB / TOL_DIV;
  localparam int HI_B = PB + PB / TOL_DIV;
  localparam int HMAX = (HI_A > HI_B) ? HI_A : HI_B;
  localparam int PW   = $clog2(HMAX + 3);
  localparam int GW   = $clog2(QUAL_CNT + 1);
  localparam logic [PW-1:0] PSAT  = PW'(HMAX + 1);
  localparam logic [GW-1:0] GFULL = GW'(QUAL_CNT);

  logic [PW-1:0] pcnt_q, pcnt_d, period, lo, hi;
  logic [GW-1:0] good_q, good_d;
  logic          have_q, have_d;
  logic          in_win;

  always_comb begin
    lo     = line_50hz ? PW'(LO_B) : PW'(LO_A);
    hi     = line_50hz ? PW'(HI_B) : PW'(HI_A);
    period = pcnt_q + 1'b1;
    in_win = (period >= lo) && (period <= hi);

    pcnt_d = pcnt_q;
    have_d = have_q;
    good_d = good_q;
    if (ac_edge) begin
      pcnt_d = '0;
      have_d = 1'b1;
      if (have_q && in_win)
        good_d = (good_q == GFULL) ? GFULL : good_q + 1'b1;
      else
        good_d = '0;
    end else begin
      if (pcnt_q != PSAT)
        pcnt_d = pcnt_q + 1'b1;
      if (pcnt_q >= hi)
        good_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      have_q <= 1'b0;
      good_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      have_q <= have_d;
      good_q <= good_d;
    end
  end

  assign ac_ready = (good_q == GFULL);

  // R4
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ac_ready) |-> $past(ac_edge))
    else $error("qualification rose without a mains edge");

  // R5
  bad_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_edge && !in_win) |=> !ac_ready)
    else $error("out-of-window period left the line qualified");

endmodule

// File: rtl/mtb_tick_gen.sv
`timescale 1ns/1ps
module mtb_tick_gen import mtb_pkg::*; #(
  parameter int XTAL_HZ   = 32768,
  parameter int TPS       = 10,
  parameter int LINE_A_HZ = 60,
  parameter int LINE_B_HZ = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ac_edge,
  input  logic use_ac,
  input  logic line_50hz,
  output logic tick,
  output logic src_ac
);

  localparam int BASE  = XTAL_HZ / TPS;
  localparam int EXTRA = XTAL_HZ % TPS;
  localparam int XW    = $clog2(BASE + 2);
  localparam int IW    = $clog2(TPS + 1);
  localparam int NA    = LINE_A_HZ / TPS;
  localparam int NB    = LINE_B_HZ / TPS;
  localparam int NMAX  = (NA > NB) ? NA : NB;
  localparam int AW    = $clog2(NMAX + 1);
  localparam int PA    = nom_period(XTAL_HZ, LINE_A_HZ);
  localparam int PB    = nom_period(XTAL_HZ, LINE_B_HZ);
  localparam logic [XW-1:0] LONG_M1  = XW'(BASE);
  localparam logic [XW-1:0] SHORT_M1 = XW'(BASE - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(TPS - 1);

  src_e          src_q, src_d;
  logic [XW-1:0] xcnt_q, xcnt_d, len_m1, pnom, carry_x;
  logic [AW-1:0] acnt_q, acnt_d, nper_m1, carry_a;
  logic [IW-1:0] idx_q, idx_d, idx_inc;
  logic          tick_q, tick_d;

  // Phase translation between the two units.
  always_comb begin
    pnom    = line_50hz ? XW'(PB) : XW'(PA);
    nper_m1 = line_50hz ? AW'(NB - 1) : AW'(NA - 1);
    len_m1  = (idx_q < IW'(EXTRA)) ? LONG_M1 : SHORT_M1;
    idx_inc = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    carry_x = XW'(acnt_q) * pnom;
    carry_a = '0;
    for (int k = 1; k < NMAX; k++) begin
      if ((AW'(k) <= nper_m1) && (xcnt_q >= XW'(k) * pnom))
        carry_a = AW'(k);
    end
  end

  // Next state.
  always_comb begin
    src_d  = use_ac ? SRC_AC : SRC_XTAL;
    xcnt_d = xcnt_q;
    acnt_d = acnt_q;
    idx_d  = idx_q;
    tick_d = 1'b0;
    if (src_d != src_q) begin
      if (src_d == SRC_AC) begin
        acnt_d = carry_a;
        xcnt_d = '0;
      end else begin
        xcnt_d = carry_x;
        acnt_d = '0;
      end
    end else if (src_q == SRC_XTAL) begin
      if (xcnt_q >= len_m1) begin
        tick_d = 1'b1;
        xcnt_d = '0;
        idx_d  = idx_inc;
      end else begin
        xcnt_d = xcnt_q + 1'b1;
      end
    end else if (ac_edge) begin
      if (acnt_q >= nper_m1) begin
        tick_d = 1'b1;
        acnt_d = '0;
        idx_d  = idx_inc;
      end else begin
        acnt_d = acnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_XTAL;
      xcnt_q <= '0;
      acnt_q <= '0;
      idx_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      xcnt_q <= xcnt_d;
      acnt_q <= acnt_d;
      idx_q  <= idx_d;
      tick_q <= tick_d;
    end
  end

  assign tick   = tick_q;
  assign src_ac = (src_q == SRC_AC);

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q)
    else $error("ticks on consecutive cycles");

  // R2
  xcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_XTAL) |-> (xcnt_q <= LONG_M1))
    else $error("crystal phase beyond longest tick");

  // R6
  src_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !use_ac |=> !src_ac)
    else $error("mains source kept without qualification or with power failed");

endmodule

// File: rtl/mtb_fout_div.sv
`timescale 1ns/1ps
module mtb_fout_div #(
  parameter int NSEL   = 7,
  parameter int FSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FSEL_W-1:0] fout_sel,
  output logic              fout
);

  localparam int CW = 2 * NSEL - 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fout_q, fout_d;

  always_comb begin
    cnt_d  = cnt_q + 1'b1;
    fout_d = 1'b0;
    for (int s = 1; s <= NSEL; s++) begin
      if (fout_sel == FSEL_W'(s))
        fout_d = cnt_q[2*s-2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fout_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fout_q <= fout_d;
    end
  end

  assign fout = fout_q;

  // R8
  fout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fout_sel == '0) |=> !fout_q)
    else $error("frequency output active while disabled");

endmodule

// File: rtl/mains_timebase.sv
`timescale 1ns/1ps
module mains_timebase import mtb_pkg::*; #(
  parameter  int XTAL_HZ     = 32768,
  parameter  int TPS         = 10,
  parameter  int LINE_A_HZ   = 60,
  parameter  int LINE_B_HZ   = 50,
  parameter  int TOL_DIV     = 20,
  parameter  int QUAL_CNT    = 8,
  parameter  int SYNC_STAGES = 2,
  parameter  int FOUT_SELS   = 7,
  localparam int FSEL_W      = $clog2(FOUT_SELS + 1)
) (
  input  logic              clk_xtal,
  input  logic              rst_n,
  input  logic              ac_pulse,
  input  logic              line_50hz,
  input  logic              pwr_fail,
  input  logic [FSEL_W-1:0] fout_sel,
  output logic              tick,
  output logic              ac_ready,
  output logic              src_ac,
  output logic              fout
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       ac_edge;
  logic       use_ac;

  // Reset asserted asynchronously, released on the clock.
  always_ff @(posedge clk_xtal or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mtb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_xtal),
    .rst_n    (rst_int_n),
    .async_in (ac_pulse),
    .rise     (ac_edge)
  );

  mtb_ac_qual #(
    .XTAL_HZ   (XTAL_HZ),
    .LINE_A_HZ (LINE_A_HZ),
    .LINE_B_HZ (LINE_B_HZ),
    .TOL_DIV   (TOL_DIV),
    .QUAL_CNT  (QUAL_CNT)
  ) u_qual (
    .clk       (clk_xtal),
    .rst_n     (rst_int_n),
    .ac_edge   (ac_edge),
    .line_50hz (line_50hz),
    .ac_ready  (ac_ready)
  );

  assign use_ac = ac_ready & ~pwr_fail;

  mtb_tick_gen #(
    .XTAL_HZ   (XTAL_HZ),
    .TPS       (TPS),
    .LINE_A_HZ (LINE_A_HZ),
    .LINE_B_HZ (LINE_B_HZ)
  ) u_tick (
    .clk       (clk_xtal),
    .rst_n     (rst_int_n),
    .ac_edge   (ac_edge),
    .use_ac    (use_ac),
    .line_50hz (line_50hz),
    .tick      (tick),
    .src_ac    (src_ac)
  );

  mtb_fout_div #(.NSEL(FOUT_SELS), .FSEL_W(FSEL_W)) u_fout (
    .clk      (clk_xtal),
    .rst_n    (rst_int_n),
    .fout_sel (fout_sel),
    .fout     (fout)
  );

endmodule

// File: tb/test_mains_timebase.sv
`timescale 1ns/1ps
module test_mains_timebase;

  typedef struct {
    int    lo;
    int    hi;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ac_pulse = 1'b0;
  logic       line_50hz = 1'b0;
  logic       pwr_fail = 1'b0;
  logic [2:0] fout_sel = 3'd0;
  logic       tick, ac_ready, src_ac, fout;

  int   n_cmp = 0, n_bad = 0;
  int   cyc = 0, tick_n = 0, last_tick = 0;
  bit   ac_on = 1'b0;
  int   ac_per = 546, ac_bad = 0, ac_edges = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  mains_timebase i_mains_timebase (
    .clk_xtal (clk), .rst_n (rst_n), .ac_pulse (ac_pulse),
    .line_50hz (line_50hz), .pwr_fail (pwr_fail), .fout_sel (fout_sel),
    .tick (tick), .ac_ready (ac_ready), .src_ac (src_ac), .fout (fout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic int xlen(input int m);
    return (((m - 1) % 10) < 8) ? 3277 : 3276;
  endfunction

  // Monitor: measures each tick interval and compares it with the queue head.
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (tick) begin
      tick_n++;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk((cyc - last_tick >= e.lo) && (cyc - last_tick <= e.hi),
            e.req, cyc - last_tick, e.lo);
      end
      last_tick = cyc;
    end
  end

  // Mains waveform generator: one iteration per period.
  initial begin
    forever begin
      if (ac_on) begin
        int cur;
        cur = (ac_bad != 0) ? ac_bad : ac_per;
        ac_bad = 0;
        @(negedge clk);
        ac_pulse = 1'b1;
        ac_edges++;
        repeat (cur / 2) @(negedge clk);
        ac_pulse = 1'b0;
        repeat (cur - cur / 2 - 1) @(negedge clk);
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic wait_tick;
    do @(negedge clk); while (!tick);
    #1;
  endtask

  task automatic drain;
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic push_xtal(input int k, input string r);
    wait_tick();
    for (int i = 1; i <= k; i++) q.push_back('{xlen(tick_n + i), xlen(tick_n + i), r});
  endtask

  task automatic push_span(input int p);
    #1;
    q.push_back('{3276 - p - 80, 3277 + p + 80, "R7"});
  endtask

  task automatic wait_edges(input int target);
    wait (ac_edges >= target);
    repeat (6) @(negedge clk);
  endtask

  task automatic measure_fout(output int p);
    int c;
    c = 0;
    while (fout) @(negedge clk);
    while (!fout) @(negedge clk);
    while (fout) begin @(negedge clk); c++; end
    while (!fout) begin @(negedge clk); c++; end
    p = c;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    finish_run();
  end

  initial begin
    int e, e0, p, highs;
    fout_sel = 3'd1;
    repeat (6) @(negedge clk);
    // R1: reset state
    chk(tick == 0, "R1 tick", tick, 0);
    chk(ac_ready == 0, "R1 ac_ready", ac_ready, 0);
    chk(src_ac == 0, "R1 src_ac", src_ac, 0);
    chk(fout == 0, "R1 fout", fout, 0);
    fout_sel = 3'd0;
    rst_n = 1'b1;

    // R2: crystal pattern over a full group
    push_xtal(10, "R2 crystal tick length");
    drain();

    // R4, R6, R3 at 60 Hz
    ac_per = 546; line_50hz = 1'b0; e = ac_edges; ac_on = 1'b1;
    wait_edges(e + 8);
    chk(ac_ready == 0, "R4 not yet qualified", ac_ready, 0);
    wait_edges(e + 9);
    chk(ac_ready == 1, "R4 qualified at 60Hz", ac_ready, 1);
    chk(src_ac == 1, "R6 mains selected", src_ac, 1);
    push_span(546);
    for (int i = 0; i < 3; i++) q.push_back('{3276, 3276, "R3 60Hz tick = 6 periods"});
    drain();

    // R5: one stretched period
    e0 = ac_edges;
    wait (ac_edges != e0);
    #1;
    ac_bad = 600;
    e = ac_edges;
    wait_edges(e + 2);
    chk(ac_ready == 0, "R5 drop on bad period", ac_ready, 0);
    chk(src_ac == 0, "R6 crystal after drop", src_ac, 0);
    push_span(600);
    drain();

    // R4: requalify after 8 good periods
    wait_edges(e + 10);
    chk(ac_ready == 1, "R4 requalified", ac_ready, 1);
    chk(src_ac == 1, "R6 mains reselected", src_ac, 1);
    push_span(546);
    q.push_back('{3276, 3276, "R3 60Hz after requalify"});
    drain();

    // R6: power fail forces crystal while line stays qualified
    pwr_fail = 1'b1;
    repeat (4) @(negedge clk);
    chk(src_ac == 0, "R6 power fail selects crystal", src_ac, 0);
    chk(ac_ready == 1, "R6 line still qualified", ac_ready, 1);
    push_span(546);
    drain();
    push_xtal(3, "R2 crystal after power fail");
    drain();
    pwr_fail = 1'b0;
    repeat (4) @(negedge clk);
    chk(src_ac == 1, "R6 power back selects mains", src_ac, 1);
    push_span(546);
    q.push_back('{3276, 3276, "R3 60Hz after power return"});
    drain();

    // R5: line stops entirely
    ac_on = 1'b0;
    repeat (700) @(negedge clk);
    chk(ac_ready == 0, "R5 timeout drop", ac_ready, 0);
    chk(src_ac == 0, "R6 crystal on timeout", src_ac, 0);

    // R3, R4 at 50 Hz
    line_50hz = 1'b1; ac_per = 655; e = ac_edges; ac_on = 1'b1;
    wait_edges(e + 8);
    chk(ac_ready == 0, "R4 50Hz not yet qualified", ac_ready, 0);
    wait_edges(e + 9);
    chk(ac_ready == 1, "R4 qualified at 50Hz", ac_ready, 1);
    push_span(655);
    for (int i = 0; i < 2; i++) q.push_back('{3275, 3275, "R3 50Hz tick = 5 periods"});
    drain();

    // R8: frequency output
    fout_sel = 3'd0;
    repeat (3) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (fout) highs++;
    end
    chk(highs == 0, "R8 disabled output", highs, 0);
    fout_sel = 3'd1;
    measure_fout(p);
    chk(p == 2, "R8 select 1 period", p, 2);
    fout_sel = 3'd2;
    measure_fout(p);
    chk(p == 8, "R8 select 2 period", p, 8);
    fout_sel = 3'd3;
    measure_fout(p);
    chk(p == 32, "R8 select 3 period", p, 32);

    finish_run();
  end

endmodule